// File: doc/BRIEF.md
# Masked Vectored Interrupt Encoder

This block sits between eight device interrupt lines and a processor that takes single-byte restart instructions as interrupt vectors. Each request line is active low and rests high. A mask register, loaded by an I/O write to a fixed port address, can block any subset of the lines. Among the lines that are both pulled low and not blocked, the one with the lowest number wins. When a global enable is on and any such line is pending, the block raises its interrupt request to the processor.

When the processor acknowledges, the block drives the restart opcode for the winning line onto its data output and raises an output-enable flag. Restart n sends the processor to address n×8. The opcode is C7h with n placed in bits 5:3, so the eight vectors run from C7h (line 0) to FFh (line 7). The line number is captured on the last clock edge before acknowledge rises and holds for the whole acknowledge. Outside acknowledge the output is released: the enable flag is low and the data reads 00h.

Top module: `vint_encoder`

## Requirements
- R1: After reset the mask is 00h, so every line is enabled. With the enable on, pulling any single line low raises `irq` in the same cycle.
- R2: A write with `io_wr` high and `io_addr` equal to FEh loads `io_wdata` into the mask at that clock edge. Mask bit k set to 1 blocks line k, and 0 lets it through. Example masks: E0h blocks lines 5 to 7, 04h blocks line 2, and FFh blocks every line.
- R3: An I/O write to any other address leaves the mask unchanged.
- R4: When several unmasked lines are low, the lowest-numbered one is chosen. Line 0 has the highest priority and line 7 the lowest.
- R5: `irq` is high exactly when `vec_en` is high and at least one unmasked line is low. It responds combinationally to the lines, the mask and the enable.
- R6: With `vec_en` low, `irq` stays low and an acknowledge returns FFh whatever the lines show.
- R7: While `ack` is high, `vec_oe` is high and `vec_out` equals C7h OR (n shifted left by 3), where n is the chosen line.
- R8: While `ack` is low, `vec_oe` is low and `vec_out` is 00h.
- R9: The line number is captured on the last rising edge with `ack` low. Changes on the lines or the mask during acknowledge do not change `vec_out`.
- R10: An acknowledge with no pending unmasked line returns FFh, which is restart 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the mask |
| req_n | input | 8 | Interrupt request lines, active low |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| vec_en | input | 1 | Global enable for vector generation |
| ack | input | 1 | Interrupt acknowledge from the processor |
| irq | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Restart opcode during acknowledge, 00h otherwise |
| vec_oe | output | 1 | High while the opcode is being driven |

## Verification
There are three different latencies to respect. `irq` is combinational, so it is sampled at the falling edge in the same half-cycle that the lines are set. A mask write takes effect one rising edge after the strobe, so checks that rely on it come after that edge. The opcode depends on the line number captured at the last rising edge before `ack`, so the bench sets the lines, lets one rising edge pass, raises `ack` at a falling edge and samples shortly afterwards. The freeze check changes the lines while `ack` is high, lets a rising edge pass and samples again.

// File: rtl/vint_encoder.sv
module vint_encoder #(
  parameter int          NUM_LINES = 8,
  parameter int          DATA_W    = 8,
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  MASK_PORT = 8'hFE,
  parameter logic [7:0]  RST_BASE  = 8'hC7,
  parameter int          VEC_SHIFT = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] req_n,
  input  logic                 io_wr,
  input  logic [ADDR_W-1:0]    io_addr,
  input  logic [DATA_W-1:0]    io_wdata,
  input  logic                 vec_en,
  input  logic                 ack,
  output logic                 irq,
  output logic [DATA_W-1:0]    vec_out,
  output logic                 vec_oe
);
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam logic [IDX_W-1:0] IDX_NONE = IDX_W'(NUM_LINES - 1);

  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] live;
  logic [IDX_W-1:0]     sel_idx;
  logic [IDX_W-1:0]     held_idx;
  logic                 mask_hit;

  assign mask_hit = io_wr && (io_addr == ADDR_W'(MASK_PORT));
  assign live     = vec_en ? (~req_n & ~mask_q) : '0;
  assign irq      = |live;

  always_comb begin
    sel_idx = IDX_NONE;
    for (int i = NUM_LINES - 1; i >= 0; i--)
      if (live[i]) sel_idx = IDX_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (mask_hit) mask_q <= io_wdata[NUM_LINES-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_idx <= IDX_NONE;
    else if (!ack) held_idx <= sel_idx;
  end

  assign vec_oe  = ack;
  assign vec_out = ack ? (DATA_W'(RST_BASE) | (DATA_W'(held_idx) << VEC_SHIFT)) : '0;

  assert_mask_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mask_hit |=> mask_q == $past(io_wdata[NUM_LINES-1:0]));

  assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_hit |=> $stable(mask_q));

  assert_winner_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!req_n[sel_idx] && !mask_q[sel_idx]));

  assert_enable_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_en |-> !irq);

  assert_opcode_form_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> (vec_out[2:0] == 3'b111 && vec_out[7:6] == 2'b11));

  assert_ack_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && $past(ack)) |-> $stable(vec_out));
endmodule

// File: tb/sim_vint_encoder.sv
module sim_vint_encoder;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_n = 8'hFF;
  logic       io_wr = 1'b0;
  logic [7:0] io_addr = '0;
  logic [7:0] io_wdata = '0;
  logic       vec_en = 1'b1;
  logic       ack = 1'b0;
  logic       irq;
  logic [7:0] vec_out;
  logic       vec_oe;

  int checks = 0;
  int errors = 0;

  vint_encoder u0 (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .vec_en(vec_en), .ack(ack), .irq(irq),
    .vec_out(vec_out), .vec_oe(vec_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {mask, req_n, vec_en, exp_irq, exp_opcode}
  localparam logic [25:0] VEC [13] = '{
    {8'h00, 8'hFF, 1'b1, 1'b0, 8'hFF},
    {8'h00, 8'hFE, 1'b1, 1'b1, 8'hC7},
    {8'h00, 8'h7F, 1'b1, 1'b1, 8'hFF},
    {8'h00, 8'h00, 1'b1, 1'b1, 8'hC7},
    {8'h00, 8'hF3, 1'b1, 1'b1, 8'hD7},
    {8'h04, 8'hFB, 1'b1, 1'b0, 8'hFF},
    {8'h04, 8'hF3, 1'b1, 1'b1, 8'hDF},
    {8'hE0, 8'h1F, 1'b1, 1'b0, 8'hFF},
    {8'hE0, 8'h0F, 1'b1, 1'b1, 8'hE7},
    {8'hFF, 8'h00, 1'b1, 1'b0, 8'hFF},
    {8'h00, 8'hFD, 1'b0, 1'b0, 8'hFF},
    {8'h7F, 8'h00, 1'b1, 1'b1, 8'hFF},
    {8'h01, 8'hFC, 1'b1, 1'b1, 8'hCF}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] addr, input logic [7:0] data);
    @(negedge clk);
    io_wr = 1'b1; io_addr = addr; io_wdata = data;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic do_ack(output logic [7:0] op, output logic oe);
    @(negedge clk);
    ack = 1'b1;
    #1;
    op = vec_out; oe = vec_oe;
  endtask

  task automatic end_ack;
    @(negedge clk);
    ack = 1'b0;
    #1;
    chk("R8 oe released", {7'b0, vec_oe}, 8'h00);
    chk("R8 data released", vec_out, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] op;
    logic       oe;
    repeat (3) @(negedge clk);
    #1;
    chk("R8 reset oe", {7'b0, vec_oe}, 8'h00);
    chk("R1 reset idle irq", {7'b0, irq}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    req_n = 8'hEF;
    #1;
    chk("R1 reset mask open line4", {7'b0, irq}, 8'h01);
    req_n = 8'hFF;

    for (int k = 0; k < 13; k++) begin
      io_write(8'hFE, VEC[k][25:18]);
      req_n  = VEC[k][17:10];
      vec_en = VEC[k][9];
      #1;
      chk($sformatf("R5 irq vec %0d", k), {7'b0, irq}, {7'b0, VEC[k][8]});
      do_ack(op, oe);
      chk($sformatf("R7 opcode vec %0d", k), op, VEC[k][7:0]);
      chk($sformatf("R7 oe vec %0d", k), {7'b0, oe}, 8'h01);
      end_ack();
      req_n = 8'hFF; vec_en = 1'b1;
    end

    // R3: write to a neighbouring port leaves the mask open
    io_write(8'hFE, 8'h00);
    io_write(8'hFD, 8'hFF);
    req_n = 8'hFE;
    #1;
    chk("R3 other port ignored irq", {7'b0, irq}, 8'h01);
    do_ack(op, oe);
    chk("R3 other port ignored opcode", op, 8'hC7);

    // R9: lines and mask change during acknowledge
    @(negedge clk);
    req_n = 8'hFB;
    io_wr = 1'b1; io_addr = 8'hFE; io_wdata = 8'hFF;
    @(negedge clk);
    io_wr = 1'b0;
    #1;
    chk("R9 frozen opcode", vec_out, 8'hC7);
    end_ack();
    #1;
    chk("R2 mask FF after write in ack", {7'b0, irq}, 8'h00);

    // R10: acknowledge with nothing pending
    req_n = 8'hFF;
    io_write(8'hFE, 8'h00);
    do_ack(op, oe);
    chk("R10 empty ack", op, 8'hFF);
    end_ack();

    // R6: enable off with line0 low
    vec_en = 1'b0; req_n = 8'hFE;
    #1;
    chk("R6 enable off irq", {7'b0, irq}, 8'h00);
    do_ack(op, oe);
    chk("R6 enable off opcode", op, 8'hFF);
    end_ack();
    vec_en = 1'b1; req_n = 8'hFF;

    // R1: reset clears a full mask
    io_write(8'hFE, 8'hFF);
    req_n = 8'h7F;
    #1;
    chk("R2 full mask blocks line7", {7'b0, irq}, 8'h00);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 mask cleared by reset", {7'b0, irq}, 8'h01);
    do_ack(op, oe);
    chk("R4 line7 alone opcode", op, 8'hFF);
    end_ack();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule